// File: doc/BRIEF.md
# Video Memory Write Queue with Slot-Driven Drain

This block sits between a processor's data port and the video memory controller. Each data-port write is placed in a short queue. The entry holds the written word, a master-clock timestamp and a split-commit marker. The processor's cycle count is turned into master clocks by multiplying it by seven. The video side offers external access slots. At each slot, the oldest entry is committed if its timestamp is no later than the current master-clock count. It goes to one of three internal memories, chosen by the present access code: a byte-wide pattern memory, a 16-bit colour memory or a 16-bit scroll memory.

The block owns the target address register and advances it by a programmable step after every completed commit. A pattern-memory word needs two slots. In the first, the high byte goes to the address. In the second, the low byte goes to the address with bit 0 inverted, and only then is the entry removed. When the queue is full, a new write stalls the writer, unless a slot frees an entry in the same cycle. Every data-port write also raises a pulse that clears the control-port pending flag kept outside the block.

The drain side is a three-state machine. The states are ST_EMPTY (no entries), ST_WAIT (the head entry has not been touched) and ST_SPLIT (the head's high byte has been committed). The transitions are as follows:
- EMPTY to WAIT when a write is accepted.
- WAIT to SPLIT on a pattern-memory high-byte commit.
- WAIT to EMPTY when the last entry is removed and no write arrives.
- SPLIT to WAIT when the head is removed and entries remain.
- SPLIT to EMPTY when the head is removed, it was the last entry and no write arrives.

Top module: `vid_write_queue`

## Requirements
- R1: After reset the queue is empty (q_empty=1, q_full=0), wr_stall=0, unused_slot=0, cur_addr=0 and every memory word reads 0.
- R2: The queue holds up to four entries and drains oldest first. q_full is 1 exactly when four entries are held and q_empty is 1 exactly when none are. Entries leave only at a slot.
- R3: An entry's timestamp is wr_cpu_cycle×7. A slot services the head only if the queue is non-empty and timestamp ≤ cur_cycle. Otherwise unused_slot is 1 in the cycle after the slot, and it is 0 after a serviced slot.
- R4: With acc_code=1 and the head not yet split, a slot writes wr_data[15:8] into pattern byte cur_addr. The entry stays queued and cur_addr is unchanged.
- R5: With acc_code=1 and the head split, a slot writes data[7:0] into pattern byte cur_addr^1. It then removes the entry and sets cur_addr to cur_addr+incr_step.
- R6: With acc_code=3, a slot writes the whole word into colour word cur_addr&63. It then removes the entry and advances cur_addr.
- R7: With acc_code=5, a slot writes the word into scroll word cur_addr&63 only if that index is below 40. It removes the entry and advances cur_addr either way.
- R8: With any other acc_code, a slot removes the entry and advances cur_addr but writes no memory.
- R9: wr_en on a full queue with no removal in that cycle raises wr_stall and the word is dropped. wr_en together with a removal on a full queue is accepted without stall.
- R10: pend_clr is 1 in every cycle in which wr_en is 1, and 0 otherwise.
- R11: addr_ld loads cur_addr from addr_in at the next edge. It takes precedence over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 16 | Word being written |
| wr_cpu_cycle | input | 16 | Processor cycle count of the write |
| cur_cycle | input | 19 | Current master-clock count |
| slot_en | input | 1 | External access slot strobe |
| acc_code | input | 3 | Access code selecting the target memory |
| incr_step | input | 8 | Address step after each completed commit |
| addr_ld | input | 1 | Load strobe for the address register |
| addr_in | input | 16 | Value loaded into the address register |
| rd_sel | input | 2 | Observation select: 0 pattern, 1 colour, 2 scroll |
| rd_index | input | 16 | Observation index |
| rd_value | output | 16 | Observed memory word (pattern byte zero-extended) |
| cur_addr | output | 16 | Address register |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | Queue full |
| wr_stall | output | 1 | Writer must hold its write |
| unused_slot | output | 1 | Previous slot went unused |
| pend_clr | output | 1 | Clears the external control-port pending flag |

## Verification
The hardest state to reach is a write on a full queue that lands in the same cycle as a slot which frees an entry. The bench fills the queue with four writes under the colour-memory code. It then presents one write alone, which must stall and be dropped, and one write together with a slot. It drains the rest and checks from the colour words that the dropped word is missing and that the accepted word followed its elders in order. Reaching a split pattern-memory head needs two slots per word. The bench sweeps 32 start addresses and steps through both halves for each one.

// File: rtl/vwq_pkg.sv
package vwq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SPLIT = 2'd2
    } qstate_e;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_VRAM_HI = 3'd1,
        ACT_VRAM_LO = 3'd2,
        ACT_CRAM    = 3'd3,
        ACT_VSRAM   = 3'd4,
        ACT_SKIP    = 3'd5
    } act_e;

    localparam logic [2:0] CODE_PATTERN = 3'd1;
    localparam logic [2:0] CODE_COLOUR  = 3'd3;
    localparam logic [2:0] CODE_SCROLL  = 3'd5;

endpackage

// File: rtl/vwq_store.sv
module vwq_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int TW    = 19,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_value,
    input  logic [TW-1:0] push_ts,
    input  logic          pop,
    input  logic          mark_partial,
    output logic [DW-1:0] head_value,
    output logic [TW-1:0] head_ts,
    output logic          head_partial,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);

    logic [DW-1:0] val_q  [DEPTH];
    logic [TW-1:0] ts_q   [DEPTH];
    logic          part_q [DEPTH];
    logic [LW-1:0] level_q;
    logic [LW-1:0] wr_idx;

    assign wr_idx = level_q - LW'(pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                val_q[i]  <= '0;
                ts_q[i]   <= '0;
                part_q[i] <= 1'b0;
            end
        end else begin
            if (pop) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    val_q[i]  <= val_q[i+1];
                    ts_q[i]   <= ts_q[i+1];
                    part_q[i] <= part_q[i+1];
                end
                part_q[DEPTH-1] <= 1'b0;
            end
            if (mark_partial) begin
                part_q[0] <= 1'b1;
            end
            if (push) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (LW'(i) == wr_idx) begin
                        val_q[i]  <= push_value;
                        ts_q[i]   <= push_ts;
                        part_q[i] <= 1'b0;
                    end
                end
            end
            level_q <= level_q + LW'(push) - LW'(pop);
        end
    end

    assign head_value   = val_q[0];
    assign head_ts      = ts_q[0];
    assign head_partial = part_q[0];
    assign level        = level_q;
    assign empty        = (level_q == '0);
    assign full         = (level_q == LW'(DEPTH));

endmodule

// File: rtl/vwq_commit.sv
module vwq_commit
    import vwq_pkg::*;
#(
    parameter int AW = 16,
    parameter int IW = 8,
    parameter int TW = 19,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_en,
    input  logic [2:0]    acc_code,
    input  logic [TW-1:0] cur_cycle,
    input  logic [TW-1:0] head_ts,
    input  logic          head_partial,
    input  logic          empty,
    input  logic [LW-1:0] level,
    input  logic          push,
    input  logic          addr_ld,
    input  logic [AW-1:0] addr_in,
    input  logic [IW-1:0] incr_step,
    output act_e          act,
    output logic          pop,
    output logic          mark_partial,
    output logic [AW-1:0] cur_addr,
    output logic          unused_slot,
    output qstate_e       state
);

    qstate_e       st_q, st_d;
    logic          ready;
    logic [AW-1:0] addr_q;
    logic          unused_q;
    logic          last_out;

    assign ready    = slot_en && !empty && (head_ts <= cur_cycle);
    assign last_out = (level == LW'(1)) && !push;

    // Output process: the commit action for this cycle
    always_comb begin
        act = ACT_NONE;
        if (ready) begin
            case (acc_code)
                CODE_PATTERN: act = head_partial ? ACT_VRAM_LO : ACT_VRAM_HI;
                CODE_COLOUR:  act = ACT_CRAM;
                CODE_SCROLL:  act = ACT_VSRAM;
                default:      act = ACT_SKIP;
            endcase
        end
    end

    assign pop          = (act != ACT_NONE) && (act != ACT_VRAM_HI);
    assign mark_partial = (act == ACT_VRAM_HI);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (push) st_d = ST_WAIT;
            ST_WAIT: begin
                if (mark_partial)          st_d = ST_SPLIT;
                else if (pop && last_out)  st_d = ST_EMPTY;
            end
            ST_SPLIT: begin
                if (pop) st_d = last_out ? ST_EMPTY : ST_WAIT;
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    // State and address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_EMPTY;
            addr_q   <= '0;
            unused_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            unused_q <= slot_en && !ready;
            if (addr_ld) begin
                addr_q <= addr_in;
            end else if (pop) begin
                addr_q <= addr_q + AW'(incr_step);
            end
        end
    end

    assign cur_addr    = addr_q;
    assign unused_slot = unused_q;
    assign state       = st_q;

endmodule

// File: rtl/vwq_mem.sv
module vwq_mem
    import vwq_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int VRAM_AW     = 8,
    parameter int CRAM_AW     = 6,
    parameter int VSRAM_WIN   = 64,
    parameter int VSRAM_DEPTH = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_e          act,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] value,
    input  logic [1:0]    rd_sel,
    input  logic [AW-1:0] rd_index,
    output logic [DW-1:0] rd_value
);

    localparam int BW     = DW / 2;
    localparam int VS_IW  = $clog2(VSRAM_WIN);
    localparam int VR_N   = 1 << VRAM_AW;
    localparam int CR_N   = 1 << CRAM_AW;

    logic [BW-1:0] vram  [VR_N];
    logic [DW-1:0] cram  [CR_N];
    logic [DW-1:0] vsram [VSRAM_WIN];

    logic [VRAM_AW-1:0] hi_idx, lo_idx;
    logic [VS_IW-1:0]   vs_idx, rd_vs;

    assign hi_idx = addr[VRAM_AW-1:0];
    assign lo_idx = hi_idx ^ VRAM_AW'(1);
    assign vs_idx = addr[VS_IW-1:0];
    assign rd_vs  = rd_index[VS_IW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < VR_N; i++)      vram[i]  <= '0;
            for (int i = 0; i < CR_N; i++)      cram[i]  <= '0;
            for (int i = 0; i < VSRAM_WIN; i++) vsram[i] <= '0;
        end else begin
            case (act)
                ACT_VRAM_HI: vram[hi_idx] <= value[DW-1:BW];
                ACT_VRAM_LO: vram[lo_idx] <= value[BW-1:0];
                ACT_CRAM:    cram[addr[CRAM_AW-1:0]] <= value;
                ACT_VSRAM: begin
                    if (int'(vs_idx) < VSRAM_DEPTH) vsram[vs_idx] <= value;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_sel)
            2'd0:    rd_value = {{(DW-BW){1'b0}}, vram[rd_index[VRAM_AW-1:0]]};
            2'd1:    rd_value = cram[rd_index[CRAM_AW-1:0]];
            2'd2:    rd_value = (int'(rd_vs) < VSRAM_DEPTH) ? vsram[rd_vs] : '0;
            default: rd_value = '0;
        endcase
    end

endmodule

// File: rtl/vid_write_queue.sv
module vid_write_queue
    import vwq_pkg::*;
#(
    parameter int CYC_W       = 16,
    parameter int DEPTH       = 4,
    parameter int AW          = 16,
    parameter int IW          = 8,
    parameter int VRAM_AW     = 8,
    parameter int CRAM_AW     = 6,
    parameter int VSRAM_DEPTH = 40,
    parameter int TW          = CYC_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    input  logic [CYC_W-1:0] wr_cpu_cycle,
    input  logic [TW-1:0]    cur_cycle,
    input  logic             slot_en,
    input  logic [2:0]       acc_code,
    input  logic [IW-1:0]    incr_step,
    input  logic             addr_ld,
    input  logic [AW-1:0]    addr_in,
    input  logic [1:0]       rd_sel,
    input  logic [AW-1:0]    rd_index,
    output logic [15:0]      rd_value,
    output logic [AW-1:0]    cur_addr,
    output logic             q_empty,
    output logic             q_full,
    output logic             wr_stall,
    output logic             unused_slot,
    output logic             pend_clr
);

    localparam int LW = $clog2(DEPTH + 1);

    logic [TW-1:0] push_ts, cyc_ext;
    logic          push_ok, pop, mark_partial, head_partial;
    logic [15:0]   head_value;
    logic [TW-1:0] head_ts;
    logic [LW-1:0] q_level;
    qstate_e       q_state;
    act_e          act;

    // master clocks = processor cycles * 7
    assign cyc_ext = TW'(wr_cpu_cycle);
    assign push_ts = (cyc_ext << 3) - cyc_ext;

    assign push_ok  = wr_en && (!q_full || pop);
    assign wr_stall = wr_en && q_full && !pop;
    assign pend_clr = wr_en;

    vwq_store #(.DEPTH(DEPTH), .DW(16), .TW(TW), .LW(LW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (push_ok),
        .push_value   (wr_data),
        .push_ts      (push_ts),
        .pop          (pop),
        .mark_partial (mark_partial),
        .head_value   (head_value),
        .head_ts      (head_ts),
        .head_partial (head_partial),
        .level        (q_level),
        .empty        (q_empty),
        .full         (q_full)
    );

    vwq_commit #(.AW(AW), .IW(IW), .TW(TW), .LW(LW)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_en      (slot_en),
        .acc_code     (acc_code),
        .cur_cycle    (cur_cycle),
        .head_ts      (head_ts),
        .head_partial (head_partial),
        .empty        (q_empty),
        .level        (q_level),
        .push         (push_ok),
        .addr_ld      (addr_ld),
        .addr_in      (addr_in),
        .incr_step    (incr_step),
        .act          (act),
        .pop          (pop),
        .mark_partial (mark_partial),
        .cur_addr     (cur_addr),
        .unused_slot  (unused_slot),
        .state        (q_state)
    );

    vwq_mem #(
        .AW(AW), .DW(16), .VRAM_AW(VRAM_AW), .CRAM_AW(CRAM_AW),
        .VSRAM_WIN(64), .VSRAM_DEPTH(VSRAM_DEPTH)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .addr     (cur_addr),
        .value    (head_value),
        .rd_sel   (rd_sel),
        .rd_index (rd_index),
        .rd_value (rd_value)
    );

endmodule

// File: rtl/vwq_checker.sv
module vwq_checker
    import vwq_pkg::*;
#(
    parameter int LW = 3,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          slot_en,
    input logic          addr_ld,
    input logic          q_empty,
    input logic          q_full,
    input logic          wr_stall,
    input logic          unused_slot,
    input logic [LW-1:0] level,
    input qstate_e       state,
    input logic          head_partial,
    input logic [AW-1:0] cur_addr
);

    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));

    assert_no_drain_without_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> level >= $past(level));

    assert_unused_follows_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        unused_slot |-> $past(slot_en));

    assert_split_has_partial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPLIT) |-> (head_partial && !q_empty));

    assert_empty_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) == q_empty);

    assert_stall_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall |-> (q_full && wr_en));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_en && !addr_ld) |=> $stable(cur_addr));

endmodule

bind vid_write_queue vwq_checker #(.LW(LW), .AW(AW)) u_vwq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .slot_en      (slot_en),
    .addr_ld      (addr_ld),
    .q_empty      (q_empty),
    .q_full       (q_full),
    .wr_stall     (wr_stall),
    .unused_slot  (unused_slot),
    .level        (q_level),
    .state        (q_state),
    .head_partial (head_partial),
    .cur_addr     (cur_addr)
);

// File: tb/tb_vid_write_queue.sv
`timescale 1ns/100ps
module tb_vid_write_queue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] wr_cpu_cycle = '0;
    logic [18:0] cur_cycle = 19'h7FFFF;
    logic        slot_en = 1'b0;
    logic [2:0]  acc_code = 3'd1;
    logic [7:0]  incr_step = 8'd2;
    logic        addr_ld = 1'b0;
    logic [15:0] addr_in = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_index = '0;
    logic [15:0] rd_value;
    logic [15:0] cur_addr;
    logic        q_empty, q_full, wr_stall, unused_slot, pend_clr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vid_write_queue dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_cpu_cycle(wr_cpu_cycle), .cur_cycle(cur_cycle), .slot_en(slot_en),
        .acc_code(acc_code), .incr_step(incr_step), .addr_ld(addr_ld),
        .addr_in(addr_in), .rd_sel(rd_sel), .rd_index(rd_index),
        .rd_value(rd_value), .cur_addr(cur_addr), .q_empty(q_empty),
        .q_full(q_full), .wr_stall(wr_stall), .unused_slot(unused_slot),
        .pend_clr(pend_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push_w(input logic [15:0] d, input logic [15:0] c);
        wr_en = 1'b1; wr_data = d; wr_cpu_cycle = c;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic slot();
        slot_en = 1'b1;
        cyc();
        slot_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] a);
        addr_ld = 1'b1; addr_in = a;
        cyc();
        addr_ld = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [15:0] i, output logic [15:0] v);
        @(negedge clk);
        rd_sel = s; rd_index = i;
        #0.5;
        v = rd_value;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 q_empty", q_empty, 1);
        chk("R1 q_full", q_full, 0);
        chk("R1 wr_stall", wr_stall, 0);
        chk("R1 unused_slot", unused_slot, 0);
        chk("R1 cur_addr", cur_addr, 0);
        rd(2'd1, 16'd5, v); chk("R1 colour word", v, 0);
        rst_n = 1'b1;
        cyc();

        // R4/R5 basic pattern write
        acc_code = 3'd1; incr_step = 8'd2;
        load(16'h0010);
        push_w(16'hABCD, 16'd0);
        chk("R2 not empty after write", q_empty, 0);
        slot();
        rd(2'd0, 16'h0010, v); chk("R4 high byte", v, 16'h00AB);
        chk("R4 addr held", cur_addr, 16'h0010);
        chk("R4 entry kept", q_empty, 0);
        slot();
        rd(2'd0, 16'h0011, v); chk("R5 low byte", v, 16'h00CD);
        chk("R5 addr step", cur_addr, 16'h0012);
        chk("R5 entry removed", q_empty, 1);

        // R4/R5 sweep over start addresses and steps
        for (int a = 0; a < 32; a++) begin
            logic [15:0] base;
            logic [7:0]  hi, lo;
            base = 16'h0080 + 16'(a);
            hi = 8'(a) ^ 8'h5A;
            lo = 8'(a) + 8'h33;
            incr_step = 8'(a);
            load(base);
            push_w({hi, lo}, 16'(a));
            slot();
            rd(2'd0, base, v); chk("R4 sweep high", v, {8'h00, hi});
            chk("R4 sweep addr", cur_addr, base);
            slot();
            rd(2'd0, base ^ 16'h0001, v); chk("R5 sweep low", v, {8'h00, lo});
            chk("R5 sweep addr", cur_addr, base + 16'(a));
        end

        // R3 timestamp gate: written at cpu 20 -> master 140
        acc_code = 3'd3; incr_step = 8'd1;
        slot();
        chk("R3 empty slot unused", unused_slot, 1);
        load(16'h0021);
        push_w(16'h7777, 16'd20);
        cur_cycle = 19'd139;
        slot();
        chk("R3 early slot unused", unused_slot, 1);
        chk("R3 early slot keeps entry", q_empty, 0);
        chk("R3 early slot addr", cur_addr, 16'h0021);
        cur_cycle = 19'd140;
        slot();
        chk("R3 due slot used", unused_slot, 0);
        rd(2'd1, 16'h0021, v); chk("R3 due commit", v, 16'h7777);
        cur_cycle = 19'h7FFFF;

        // R6 colour sweep with address masking
        incr_step = 8'd0;
        for (int a = 0; a < 16; a++) begin
            logic [15:0] ad;
            ad = 16'(a * 9) + 16'h0100;
            load(ad);
            push_w(16'hC000 + 16'(a), 16'd1);
            slot();
            rd(2'd1, ad & 16'h003F, v); chk("R6 colour word", v, 16'hC000 + 16'(a));
            chk("R6 colour empty", q_empty, 1);
        end

        // R7 scroll window
        acc_code = 3'd5; incr_step = 8'd4;
        load(16'h0040);
        push_w(16'h1111, 16'd0);
        slot();
        rd(2'd2, 16'd0, v); chk("R7 scroll stored", v, 16'h1111);
        load(16'h0068);
        push_w(16'h2222, 16'd0);
        slot();
        rd(2'd2, 16'd0, v); chk("R7 out of window ignored", v, 16'h1111);
        chk("R7 addr still steps", cur_addr, 16'h006C);
        chk("R7 entry removed", q_empty, 1);
        load(16'h0027);
        push_w(16'h3333, 16'd0);
        slot();
        rd(2'd2, 16'd39, v); chk("R7 last scroll word", v, 16'h3333);

        // R8 other code: no memory write, still steps
        acc_code = 3'd0; incr_step = 8'd6;
        load(16'h0010);
        push_w(16'h1234, 16'd0);
        slot();
        chk("R8 entry removed", q_empty, 1);
        chk("R8 addr steps", cur_addr, 16'h0016);
        rd(2'd0, 16'h0010, v); chk("R8 pattern untouched", v, 16'h00AB);
        rd(2'd1, 16'h0010, v); chk("R8 colour untouched", v, 16'h0000);

        // R2/R9 full queue, stall, simultaneous push/pop
        acc_code = 3'd3; incr_step = 8'd1;
        load(16'h0000);
        push_w(16'hA000, 16'd0);
        push_w(16'hA001, 16'd0);
        push_w(16'hA002, 16'd0);
        chk("R2 three not full", q_full, 0);
        push_w(16'hA003, 16'd0);
        chk("R2 four full", q_full, 1);
        wr_en = 1'b1; wr_data = 16'hDEAD; #1;
        chk("R9 stall on full", wr_stall, 1);
        chk("R10 pend_clr with write", pend_clr, 1);
        cyc();
        wr_en = 1'b0; #0.5;
        chk("R10 pend_clr idle", pend_clr, 0);
        chk("R9 still full", q_full, 1);
        wr_en = 1'b1; wr_data = 16'hA005; slot_en = 1'b1; #1;
        chk("R9 no stall with pop", wr_stall, 0);
        cyc();
        wr_en = 1'b0; slot_en = 1'b0;
        chk("R9 full after swap", q_full, 1);
        for (int k = 0; k < 4; k++) slot();
        chk("R2 drained", q_empty, 1);
        rd(2'd1, 16'd0, v); chk("R2 order 0", v, 16'hA000);
        rd(2'd1, 16'd1, v); chk("R2 order 1", v, 16'hA001);
        rd(2'd1, 16'd2, v); chk("R2 order 2", v, 16'hA002);
        rd(2'd1, 16'd3, v); chk("R2 order 3", v, 16'hA003);
        rd(2'd1, 16'd4, v); chk("R9 accepted word", v, 16'hA005);
        rd(2'd1, 16'd5, v); chk("R9 dropped word absent", v, 16'h0000);

        // R11 load beats increment
        incr_step = 8'd4;
        load(16'h0030);
        push_w(16'h4444, 16'd0);
        addr_ld = 1'b1; addr_in = 16'h0055; slot_en = 1'b1;
        cyc();
        addr_ld = 1'b0; slot_en = 1'b0;
        chk("R11 load wins", cur_addr, 16'h0055);
        rd(2'd1, 16'h0030, v); chk("R11 commit at old addr", v, 16'h4444);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule